// File: doc/BRIEF.md
# Sleep-Level Clock Gating Controller

This block decides which clock domains and oscillator enables of a small processor subsystem are running. Software writes a four-bit mode word. Each bit of the word removes one group of clocks or generators. The block decodes the word into registered enables for these targets:

- CPU execution
- the main CPU clock
- the peripheral sub-clock
- the auxiliary low-rate clock
- the DC generator that biases the digitally controlled oscillator
- the crystal oscillator

All enables are high in the fully awake mode. Five sleep levels remove progressively more of them.

An interrupt request wakes the block at once. In the cycle the request is taken, the current mode word is saved in a one-deep slot and the live word is cleared, so every clock runs while the request is serviced. A return strobe at the end of service copies the saved word back, and the block falls back to the level it was sleeping in. Software can write the saved slot during service. This decides what the return restores, for example a wake-up that lasts past the interrupt.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all six enables are high, `live_mode` reads 0000 and `in_isr` is low.
- R2: A write with `wr_sel`=0 loads `wr_data` into the live mode word, and `live_mode` shows it after the next rising edge. The bit meanings are: bit 0 halts the CPU, bit 1 stops the crystal, bit 2 requests the DC generator off, bit 3 gates the sub-clocks. The level codes are: awake 0000, level 0 0001, level 1 0101, level 2 1001, level 3 1101, level 4 1111.
- R3: `cpu_run` and `main_clk_en` are low exactly when live bit 0 is set.
- R4: `periph_clk_en` is low exactly when live bit 3 is set.
- R5: `aux_clk_en` and `xtal_en` are low exactly when live bit 1 is set.
- R6: `dcgen_en` is high when live bit 2 is clear. It is also high when `dco_feeds_clk` is high and live bit 3 is clear. It is low in every other case. So at level 1 the generator keeps running only if the oscillator feeds the still-running peripheral clock.
- R7: If `irq_req` is high at a rising edge while `in_isr` is low, then at that same edge the live word is saved, the live word becomes 0000, all enables go high and `in_isr` goes high.
- R8: If `irq_ret` is high at a rising edge while `in_isr` is high, then at that edge the saved word becomes the live word, the enables follow it and `in_isr` goes low.
- R9: A write with `wr_sel`=1 loads the saved slot, and the next return restores that value.
- R10: Priority within one cycle is return over interrupt entry over write. A write in the same cycle as an entry or a return is dropped. `irq_req` has no effect while `in_isr` is high. `irq_ret` has no effect while `in_isr` is low.
- R11: Every output changes only at a rising clock edge. The enables reflect a write, entry or return one edge after the stimulus is sampled, which is the same edge at which `live_mode` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the mode words |
| wr_sel | input | 1 | 0 selects the live word, 1 selects the saved slot |
| wr_data | input | 4 | Mode word to write |
| irq_req | input | 1 | Interrupt request (wake) |
| irq_ret | input | 1 | Interrupt-return strobe |
| dco_feeds_clk | input | 1 | High when the controlled oscillator sources the awake clocks |
| cpu_run | output | 1 | CPU execution enable |
| main_clk_en | output | 1 | Main CPU clock enable |
| periph_clk_en | output | 1 | Peripheral sub-clock enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| dcgen_en | output | 1 | Oscillator DC generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| live_mode | output | 4 | Current live mode word |
| in_isr | output | 1 | High from interrupt entry until return |

## Verification
A corrupted live word shows up on the enable pins and on `live_mode` one edge after the write, entry or return that produced it. The bench therefore compares all six enables against an independently computed pattern at every level, including both settings of the oscillator-feed input. A lost or wrong saved slot cannot be seen until the matching return. For that reason every entry in the bench is paired with a return, and the restored word and enables are checked right after it. A wrong service flag appears as a second wake that is taken during service, or as a stray return outside service. Both are provoked and checked on the next edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W     = 4;
  localparam int BIT_HALT   = 0;
  localparam int BIT_XOFF   = 1;
  localparam int BIT_DCOFF  = 2;
  localparam int BIT_SUBOFF = 3;
  localparam int EN_W       = 6;

  typedef logic [MODE_W-1:0] mode_t;

  typedef struct packed {
    logic cpu;
    logic main;
    logic periph;
    logic aux;
    logic dcgen;
    logic xtal;
  } en_t;

  localparam mode_t MODE_AWAKE = 4'b0000;
  localparam mode_t MODE_LVL0  = 4'b0001;
  localparam mode_t MODE_LVL1  = 4'b0101;
  localparam mode_t MODE_LVL2  = 4'b1001;
  localparam mode_t MODE_LVL3  = 4'b1101;
  localparam mode_t MODE_LVL4  = 4'b1111;

  function automatic en_t mode_decode(mode_t m, logic dco_feeds);
    en_t e;
    e.cpu    = ~m[BIT_HALT];
    e.main   = ~m[BIT_HALT];
    e.periph = ~m[BIT_SUBOFF];
    e.aux    = ~m[BIT_XOFF];
    e.xtal   = ~m[BIT_XOFF];
    e.dcgen  = ~m[BIT_DCOFF] | (dco_feeds & ~m[BIT_SUBOFF]);
    return e;
  endfunction
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lpm_mode_store.sv
module lpm_mode_store
  import lpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  wr_sel,
  input  mode_t wr_data,
  input  logic  irq_req,
  input  logic  irq_ret,
  output mode_t live_nx,
  output mode_t live_q,
  output logic  busy_q
);
  mode_t save_q, save_nx;
  logic  busy_nx;
  logic  ld_live, ld_save, ld_busy;
  logic  do_ret, do_take, do_wr;

  // next-state
  always_comb begin
    do_ret  = busy_q & irq_ret;
    do_take = ~busy_q & irq_req & ~do_ret;
    do_wr   = wr_en & ~do_ret & ~do_take;
    live_nx = live_q;
    save_nx = save_q;
    busy_nx = busy_q;
    if (do_ret) begin
      live_nx = save_q;
      busy_nx = 1'b0;
    end else if (do_take) begin
      save_nx = live_q;
      live_nx = MODE_AWAKE;
      busy_nx = 1'b1;
    end else if (do_wr) begin
      if (wr_sel) save_nx = wr_data;
      else        live_nx = wr_data;
    end
    ld_live = do_ret | do_take | (do_wr & ~wr_sel);
    ld_save = do_take | (do_wr & wr_sel);
    ld_busy = do_ret | do_take;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= MODE_AWAKE;
      save_q <= MODE_AWAKE;
      busy_q <= 1'b0;
    end else begin
      if (ld_live) live_q <= live_nx;
      if (ld_save) save_q <= save_nx;
      if (ld_busy) busy_q <= busy_nx;
    end
  end
endmodule

// File: rtl/lpm_en_decode.sv
module lpm_en_decode
  import lpm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  mode_t           mode_nx,
  input  logic            dco_feeds,
  output logic [EN_W-1:0] en_q
);
  en_t             en_nx;
  logic [EN_W-1:0] en_nx_v;

  always_comb begin
    en_nx   = mode_decode(mode_nx, dco_feeds);
    en_nx_v = en_nx;
  end

  for (genvar g = 0; g < EN_W; g++) begin : g_en_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[g] <= 1'b1;
      else        en_q[g] <= en_nx_v[g];
    end
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              irq_req,
  input  logic              irq_ret,
  input  logic              dco_feeds_clk,
  output logic              cpu_run,
  output logic              main_clk_en,
  output logic              periph_clk_en,
  output logic              aux_clk_en,
  output logic              dcgen_en,
  output logic              xtal_en,
  output logic [MODE_W-1:0] live_mode,
  output logic              in_isr
);
  logic            rst_sync_n;
  mode_t           live_nx;
  mode_t           live_q;
  logic [EN_W-1:0] en_v;
  en_t             en_s;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  lpm_mode_store u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .irq_req (irq_req),
    .irq_ret (irq_ret),
    .live_nx (live_nx),
    .live_q  (live_q),
    .busy_q  (in_isr)
  );

  lpm_en_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode_nx   (live_nx),
    .dco_feeds (dco_feeds_clk),
    .en_q      (en_v)
  );

  assign en_s          = en_v;
  assign cpu_run       = en_s.cpu;
  assign main_clk_en   = en_s.main;
  assign periph_clk_en = en_s.periph;
  assign aux_clk_en    = en_s.aux;
  assign dcgen_en      = en_s.dcgen;
  assign xtal_en       = en_s.xtal;
  assign live_mode     = live_q;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       irq_req,
  input logic       irq_ret,
  input logic       wr_en,
  input logic       dco_feeds_clk,
  input logic       cpu_run,
  input logic       main_clk_en,
  input logic       periph_clk_en,
  input logic       aux_clk_en,
  input logic       dcgen_en,
  input logic       xtal_en,
  input logic [3:0] live_mode,
  input logic       in_isr
);
  AST_MAIN_FOLLOWS_HALT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (main_clk_en == !live_mode[0]) && (cpu_run == !live_mode[0])); // R3
  AST_PERIPH_FOLLOWS_SUB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    periph_clk_en == !live_mode[3]); // R4
  AST_AUX_XTAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (aux_clk_en == !live_mode[1]) && (xtal_en == !live_mode[1])); // R5
  AST_DCGEN_RULE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dcgen_en == (!live_mode[2] || ($past(dco_feeds_clk) && !live_mode[3]))); // R6
  AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_isr && irq_req) |=> (in_isr && live_mode == 4'b0000 && cpu_run && main_clk_en
                              && periph_clk_en && aux_clk_en && xtal_en && dcgen_en)); // R7
  AST_RETURN_LEAVES_SERVICE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_isr && irq_ret) |=> !in_isr); // R8
  AST_STRAY_RETURN_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_isr && !irq_req && !wr_en) |=> (!in_isr && live_mode == $past(live_mode))); // R10
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk i_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .irq_req       (irq_req),
  .irq_ret       (irq_ret),
  .wr_en         (wr_en),
  .dco_feeds_clk (dco_feeds_clk),
  .cpu_run       (cpu_run),
  .main_clk_en   (main_clk_en),
  .periph_clk_en (periph_clk_en),
  .aux_clk_en    (aux_clk_en),
  .dcgen_en      (dcgen_en),
  .xtal_en       (xtal_en),
  .live_mode     (live_mode),
  .in_isr        (in_isr)
);

// File: tb/test_lpm_clk_ctrl.sv
module test_lpm_clk_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_sel, irq_req, irq_ret, dco;
  logic [3:0] wr_data;
  logic       cpu_run, main_clk_en, periph_clk_en, aux_clk_en, dcgen_en, xtal_en;
  logic [3:0] live_mode;
  logic       in_isr;
  int         errors = 0;
  int         checks = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  lpm_clk_ctrl i_lpm_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_req(irq_req), .irq_ret(irq_ret), .dco_feeds_clk(dco),
    .cpu_run(cpu_run), .main_clk_en(main_clk_en), .periph_clk_en(periph_clk_en),
    .aux_clk_en(aux_clk_en), .dcgen_en(dcgen_en), .xtal_en(xtal_en),
    .live_mode(live_mode), .in_isr(in_isr)
  );

  // enable order: cpu, main, periph, aux, dcgen, xtal
  wire [5:0] en = {cpu_run, main_clk_en, periph_clk_en, aux_clk_en, dcgen_en, xtal_en};

  // {mode[10:7], dco[6], expected enables[5:0]}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {4'b0000, 1'b0, 6'b111111},
    {4'b0001, 1'b0, 6'b001111},
    {4'b0101, 1'b0, 6'b001101},
    {4'b0101, 1'b1, 6'b001111},
    {4'b1001, 1'b0, 6'b000111},
    {4'b1101, 1'b0, 6'b000101},
    {4'b1101, 1'b1, 6'b000101},
    {4'b1111, 1'b0, 6'b000000},
    {4'b1111, 1'b1, 6'b000000},
    {4'b0010, 1'b0, 6'b111010}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 4'h0;
    irq_req = 1'b0; irq_ret = 1'b0; dco = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset enables", {2'b0, en}, 8'h3f);
    chk("R1 reset mode", {3'b0, in_isr, live_mode}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {2'b0, en}, 8'h3f);

    // table walk: R2 readback, R3/R4/R5/R6 decode
    for (int i = 0; i < NV; i++) begin
      dco = VEC[i][6];
      do_write(1'b0, VEC[i][10:7]);
      chk("R2 live readback", {4'b0, live_mode}, {4'b0, VEC[i][10:7]});
      chk("R3/R4/R5/R6 enables", {2'b0, en}, {2'b0, VEC[i][5:0]});
    end

    // R7 wake from level 3, R8 return
    dco = 1'b0;
    do_write(1'b0, 4'b1101);
    pulse_irq();
    chk("R7 wake mode", {3'b0, in_isr, live_mode}, 8'h10);
    chk("R7 wake enables", {2'b0, en}, 8'h3f);
    pulse_ret();
    chk("R8 restored mode", {3'b0, in_isr, live_mode}, 8'h0d);
    chk("R8 restored enables", {2'b0, en}, 8'b00000101);

    // R10: stray return ignored
    pulse_ret();
    chk("R10 stray return", {3'b0, in_isr, live_mode}, 8'h0d);

    // R10: second request during service ignored
    do_write(1'b0, 4'b0001);
    pulse_irq();
    do_write(1'b0, 4'b1111);
    pulse_irq();
    chk("R10 irq during service", {3'b0, in_isr, live_mode}, 8'h1f);
    pulse_ret();
    chk("R8 return after nested", {3'b0, in_isr, live_mode}, 8'h01);

    // R9: saved slot rewritten during service
    do_write(1'b0, 4'b1111);
    pulse_irq();
    do_write(1'b1, 4'b0000);
    chk("R9 live unaffected", {3'b0, in_isr, live_mode}, 8'h10);
    pulse_ret();
    chk("R9 restored override", {3'b0, in_isr, live_mode}, 8'h00);
    chk("R9 enables awake", {2'b0, en}, 8'h3f);

    // R10: return beats write in the same cycle
    do_write(1'b0, 4'b1001);
    pulse_irq();
    @(negedge clk); irq_ret = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1111;
    @(negedge clk); irq_ret = 1'b0; wr_en = 1'b0;
    chk("R10 return over write", {3'b0, in_isr, live_mode}, 8'h09);

    // R10: entry beats write in the same cycle
    do_write(1'b0, 4'b0001);
    @(negedge clk); irq_req = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1111;
    @(negedge clk); irq_req = 1'b0; wr_en = 1'b0;
    chk("R10 entry over write", {3'b0, in_isr, live_mode}, 8'h10);
    pulse_ret();
    chk("R10 write dropped at entry", {3'b0, in_isr, live_mode}, 8'h01);

    // R11: enables still at old level until the edge after a write
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1111;
    chk("R11 no change before edge", {2'b0, en}, 8'b00001111);
    @(negedge clk); wr_en = 1'b0;
    chk("R11 change one edge later", {2'b0, en}, 8'h00);

    // R1: reset during service
    pulse_irq();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset in service", {3'b0, in_isr, live_mode}, 8'h00);
    chk("R1 reset enables", {2'b0, en}, 8'h3f);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule